// File: doc/BRIEF.md
# Multi-Mode Transmit Lane Serializer

This block sits between user logic and the output stage of a source-synchronous transmit link to a transceiver. It runs on the clock that the transceiver returns. It takes one 32-bit sample word per sample slot and spreads it over one or more cycles. In each cycle every active lane receives an 8-bit group of bit-times, most significant bit-time first. A downstream serializer with a fixed rate shifts these groups out. In single data rate (SDR) modes each data bit fills two adjacent bit-time positions. In double data rate (DDR) modes each position carries its own bit.

Three settings select the mode: lane count, per-lane symbol width and SDR/DDR. One sequencer covers every combination. At the start of each slot it raises a one-cycle request, and user logic answers in the same cycle with a valid flag and the word. A strobe group marks the first bit-time of every symbol and stays aligned with the data. Settings may change at runtime, but they are best changed while reset is held.

Top module: `txser_top`

## Requirements
- R1: `tx_req` is high for exactly one cycle at the start of every sample slot, and the slot length in cycles is the symbol width divided by 4 (SDR) or by 8 (DDR). This gives 8/4 cycles for 32-bit symbols, 4/2 for 16-bit and 2/1 for 8-bit. The first request comes in the first cycle after reset is released.
- R2: Lane `l` carries the symbol taken from the sample word starting at bit `31 - l*W` and running downward for W bits. In one-lane modes with a 16-bit or 8-bit symbol, only the word's MSBs are sent.
- R3: Bit 7 of each lane group is the earliest bit-time. In DDR each of the 8 positions holds the next symbol bit. In SDR each symbol bit fills two adjacent positions, so 4 bits are sent per cycle.
- R4: The group for cycle k of a slot appears on `out_lanes` in the cycle after the k-th cycle of the slot. The first group of a slot therefore appears in the cycle that follows `tx_req`.
- R5: If `in_valid` is low while `tx_req` is high, the whole slot sends zeros. `in_valid` and `in_data` have no effect in cycles without `tx_req`.
- R6: `out_strobe` is 8'hC0 (SDR) or 8'h80 (DDR) in the first output cycle of each symbol and 0 in every other cycle.
- R7: Lanes at or above the configured lane count output zero. Lane `l` occupies `out_lanes[8l+7:8l]`.
- R8: While `rst` is high, `tx_req` is low. One edge after `rst` is sampled high, `out_lanes` and `out_strobe` are zero.
- R9: Setting codes are lanes 0/1/2 = 1/2/4 lanes and width 0/1/2 = 32/16/8 bits. Code 3 in either field, or a lane count times width above 32, is unsupported: no requests are issued and the outputs stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock returned by the transceiver |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lanes | input | 2 | Lane count code (R9) |
| cfg_width | input | 2 | Symbol width code (R9) |
| cfg_ddr | input | 1 | 1 = DDR, 0 = SDR |
| tx_req | output | 1 | Sample request, one cycle per slot |
| in_valid | input | 1 | User sample present, sampled with `tx_req` |
| in_data | input | 32 | User sample word |
| out_lanes | output | 32 | Four 8-bit lane groups |
| out_strobe | output | 8 | Symbol-start strobe group |

## Verification
`tx_req` is combinational from the slot counter and reset, so the bench reads it in the same cycle in which it answers with data. Each output group is registered once, so group k of a slot is due one edge after the k-th slot cycle. Reset clears the outputs after a single edge. The bench drives inputs and samples outputs at the falling edge. It keeps its own slot counter from the release of reset and compares each group against a prediction made the cycle before.

// File: rtl/txser_pkg.sv
package txser_pkg;

    localparam int SAMPLE_W   = 32;
    localparam int MAX_LANES  = 4;
    localparam int GROUP_W    = 8;
    localparam int LANE_BUS_W = MAX_LANES * GROUP_W;

    typedef struct packed {
        logic [LANE_BUS_W-1:0] lanes;
        logic [GROUP_W-1:0]    strobe;
    } beat_t;

    // lane count code: 0->1, 1->2, 2->4 (R9)
    function automatic logic [2:0] lanes_of(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    // width code: 0->32, 1->16, 2->8 (R9)
    function automatic logic [5:0] width_of(input logic [1:0] code);
        case (code)
            2'd0:    return 6'd32;
            2'd1:    return 6'd16;
            2'd2:    return 6'd8;
            default: return 6'd0;
        endcase
    endfunction

    function automatic logic mode_ok(input logic [1:0] lc, input logic [1:0] wc);
        logic [8:0] total;
        total = 9'(lanes_of(lc)) * 9'(width_of(wc));
        return (lanes_of(lc) != 3'd0) && (width_of(wc) != 6'd0) && (total <= 9'd32);
    endfunction

    // cycles per sample slot (R1)
    function automatic logic [3:0] slot_ratio(input logic [1:0] wc, input logic ddr);
        logic [5:0] w;
        w = width_of(wc);
        return ddr ? 4'(w >> 3) : 4'(w >> 2);
    endfunction

endpackage

// File: rtl/txser_seq.sv
module txser_seq #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             legal,
    input  logic [CNT_W:0]   ratio,
    output logic [CNT_W-1:0] phase,
    output logic             req
);

    always_ff @(posedge clk) begin
        if (rst || !legal) begin
            phase <= '0;
        end else if ({1'b0, phase} >= ratio - 1'b1) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // one request per slot, none in reset or unsupported modes (R1, R8, R9)
    assign req = !rst && legal && (phase == '0);

endmodule

// File: rtl/txser_lane.sv
module txser_lane #(
    parameter int LANE_IDX = 0,
    parameter int SAMPLE_W = 32,
    parameter int GROUP_W  = 8,
    parameter int CNT_W    = 3
) (
    input  logic [SAMPLE_W-1:0] word,
    input  logic [5:0]          sym_w,
    input  logic [2:0]          lane_cnt,
    input  logic                legal,
    input  logic                ddr,
    input  logic [CNT_W-1:0]    phase,
    output logic [GROUP_W-1:0]  bits
);

    localparam int HALF = GROUP_W / 2;

    logic [7:0]          lane_shift;
    logic [7:0]          phase_shift;
    logic [SAMPLE_W-1:0] aligned;
    logic [SAMPLE_W-1:0] shifted;
    logic                active;

    always_comb begin
        lane_shift  = 8'(LANE_IDX) * 8'(sym_w);
        phase_shift = 8'(phase) * (ddr ? 8'(GROUP_W) : 8'(HALF));
        // symbol left-aligned, then current group moved to the top (R2)
        aligned     = word << lane_shift;
        shifted     = aligned << phase_shift;
        active      = legal && (lane_cnt > 3'(LANE_IDX));
        bits        = '0;
        if (active) begin
            if (ddr) begin
                bits = shifted[SAMPLE_W-1 -: GROUP_W];
            end else begin
                // SDR: each bit fills two bit-times (R3)
                for (int i = 0; i < HALF; i++) begin
                    bits[GROUP_W-1-2*i] = shifted[SAMPLE_W-1-i];
                    bits[GROUP_W-2-2*i] = shifted[SAMPLE_W-1-i];
                end
            end
        end
    end

endmodule

// File: rtl/txser_top.sv
module txser_top
    import txser_pkg::*;
#(
    parameter int SAMPLE_W  = txser_pkg::SAMPLE_W,
    parameter int MAX_LANES = txser_pkg::MAX_LANES,
    parameter int GROUP_W   = txser_pkg::GROUP_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1:0]                   cfg_lanes,
    input  logic [1:0]                   cfg_width,
    input  logic                         cfg_ddr,
    output logic                         tx_req,
    input  logic                         in_valid,
    input  logic [SAMPLE_W-1:0]          in_data,
    output logic [MAX_LANES*GROUP_W-1:0] out_lanes,
    output logic [GROUP_W-1:0]           out_strobe
);

    localparam int CNT_W = $clog2(SAMPLE_W / (GROUP_W / 2));

    logic                         legal;
    logic [CNT_W-1:0]             phase;
    logic [SAMPLE_W-1:0]          held;
    logic [SAMPLE_W-1:0]          cur_word;
    logic [MAX_LANES*GROUP_W-1:0] next_lanes;
    logic [GROUP_W-1:0]           next_strobe;
    beat_t                        beat;

    assign legal = mode_ok(cfg_lanes, cfg_width);

    txser_seq #(.CNT_W(CNT_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .legal (legal),
        .ratio ((CNT_W+1)'(slot_ratio(cfg_width, cfg_ddr))),
        .phase (phase),
        .req   (tx_req)
    );

    // empty slot sends zeros (R5)
    assign cur_word = tx_req ? (in_valid ? in_data : '0) : held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (tx_req) begin
            held <= cur_word;
        end
    end

    for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
        txser_lane #(
            .LANE_IDX (l),
            .SAMPLE_W (SAMPLE_W),
            .GROUP_W  (GROUP_W),
            .CNT_W    (CNT_W)
        ) u_lane (
            .word     (cur_word),
            .sym_w    (width_of(cfg_width)),
            .lane_cnt (lanes_of(cfg_lanes)),
            .legal    (legal),
            .ddr      (cfg_ddr),
            .phase    (phase),
            .bits     (next_lanes[l*GROUP_W +: GROUP_W])
        );
    end

    // symbol-start marker (R6)
    always_comb begin
        next_strobe = '0;
        if (tx_req) begin
            next_strobe[GROUP_W-1] = 1'b1;
            next_strobe[GROUP_W-2] = !cfg_ddr;
        end
    end

    // one output register stage (R4, R8)
    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.lanes  <= next_lanes;
            beat.strobe <= next_strobe;
        end
    end

    assign out_lanes  = beat.lanes;
    assign out_strobe = beat.strobe;

endmodule

// File: rtl/txser_checker.sv
module txser_checker #(
    parameter int BUS_W   = 32,
    parameter int GROUP_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cfg_lanes,
    input logic [1:0]       cfg_width,
    input logic             cfg_ddr,
    input logic             tx_req,
    input logic [BUS_W-1:0] out_lanes,
    input logic [GROUP_W-1:0] out_strobe
);

    assert_req_single_R1: assert property (@(posedge clk) disable iff (rst)
        (tx_req && txser_pkg::slot_ratio(cfg_width, cfg_ddr) > 4'd1) |=> !tx_req);

    assert_strobe_after_req_R6: assert property (@(posedge clk) disable iff (rst)
        tx_req |=> (out_strobe != '0));

    assert_strobe_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !tx_req |=> (out_strobe == '0));

    assert_upper_lanes_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_lanes == 2'd0) |=> (out_lanes[BUS_W-1:GROUP_W] == '0));

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (out_lanes == '0 && out_strobe == '0));

    assert_reset_no_req_R8: assert property (@(posedge clk)
        rst |-> !tx_req);

    assert_illegal_no_req_R9: assert property (@(posedge clk)
        !txser_pkg::mode_ok(cfg_lanes, cfg_width) |-> !tx_req);

endmodule

bind txser_top txser_checker #(
    .BUS_W   (MAX_LANES*GROUP_W),
    .GROUP_W (GROUP_W)
) u_txser_checker (
    .clk        (clk),
    .rst        (rst),
    .cfg_lanes  (cfg_lanes),
    .cfg_width  (cfg_width),
    .cfg_ddr    (cfg_ddr),
    .tx_req     (tx_req),
    .out_lanes  (out_lanes),
    .out_strobe (out_strobe)
);

// File: tb/test_txser_top.sv
`timescale 1ns/1ps
module test_txser_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_lanes = 2'd0;
    logic [1:0]  cfg_width = 2'd0;
    logic        cfg_ddr = 1'b0;
    logic        tx_req;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [31:0] out_lanes;
    logic [7:0]  out_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    txser_top i_txser_top (
        .clk        (clk),
        .rst        (rst),
        .cfg_lanes  (cfg_lanes),
        .cfg_width  (cfg_width),
        .cfg_ddr    (cfg_ddr),
        .tx_req     (tx_req),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .out_lanes  (out_lanes),
        .out_strobe (out_strobe)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ref_lanes(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 0;
    endfunction

    function automatic int ref_width(input logic [1:0] c);
        return (c == 2'd0) ? 32 : (c == 2'd1) ? 16 : (c == 2'd2) ? 8 : 0;
    endfunction

    function automatic bit ref_legal(input logic [1:0] lc, input logic [1:0] wc);
        int l = ref_lanes(lc);
        int w = ref_width(wc);
        return (l != 0) && (w != 0) && (l * w <= 32);
    endfunction

    // expected {lanes, strobe} for cycle k of a slot carrying word
    function automatic logic [39:0] ref_beat(input logic [31:0] word, input logic [1:0] lc,
                                             input logic [1:0] wc, input bit ddr, input int k);
        logic [31:0] ln = '0;
        logic [7:0]  st = '0;
        int l_n = ref_lanes(lc);
        int w   = ref_width(wc);
        if (ref_legal(lc, wc)) begin
            for (int l = 0; l < 4; l++) begin
                for (int p = 7; p >= 0; p--) begin
                    int t = ddr ? (k * 8 + (7 - p)) : (k * 4 + (7 - p) / 2);
                    if (l < l_n) ln[l*8 + p] = word[31 - l*w - t];
                end
            end
            if (k == 0) st = ddr ? 8'h80 : 8'hC0;
        end
        return {ln, st};
    endfunction

    task automatic run_mode(input logic [1:0] lc, input logic [1:0] wc, input bit ddr, input int ncyc);
        logic [31:0] held = '0;
        logic [39:0] exp;
        bit          zero_slot = 1'b0;
        int          m = 0;
        int          slot = 0;
        bit          legal = ref_legal(lc, wc);
        int          ratio = legal ? ref_width(wc) / (ddr ? 8 : 4) : 1;

        @(negedge clk);
        rst = 1'b1;
        cfg_lanes = lc; cfg_width = wc; cfg_ddr = ddr;
        in_valid = 1'b1; in_data = $urandom;
        #1;
        chk(tx_req == 1'b0, "R8 req in reset", 64'(tx_req), 64'd0);
        @(negedge clk);
        @(negedge clk);
        chk(out_lanes == '0 && out_strobe == '0, "R8 outputs in reset",
            {24'd0, out_lanes, out_strobe}, 64'd0);
        rst = 1'b0;
        #1;
        for (int c = 0; c < ncyc; c++) begin
            bit exp_req = legal && (m == 0);
            chk(tx_req == exp_req, legal ? "R1 request timing" : "R9 no request",
                64'(tx_req), 64'(exp_req));
            if (exp_req) begin
                logic [31:0] d;
                bit v;
                if (slot == 0)      begin d = 32'hFFFF_FFFF; v = 1'b1; end
                else if (slot == 1) begin d = 32'h8000_0001; v = 1'b1; end
                else if (slot == 2) begin d = $urandom;      v = 1'b0; end
                else                begin d = $urandom;      v = ($urandom % 4) != 0; end
                in_data = d; in_valid = v;
                held = v ? d : '0;
                zero_slot = !v;
                slot++;
            end else begin
                // stimulus outside a slot start must be ignored (R5)
                in_data = $urandom; in_valid = $urandom % 2;
            end
            exp = ref_beat(held, lc, wc, ddr, m);
            m = (m + 1) % ratio;
            @(negedge clk);
            chk(out_lanes == exp[39:8],
                !legal ? "R9 zero lanes" : zero_slot ? "R5 empty slot" : "R2 R3 R4 R7 lane data",
                64'(out_lanes), 64'(exp[39:8]));
            chk(out_strobe == exp[7:0], "R6 strobe", 64'(out_strobe), 64'(exp[7:0]));
        end
        // reset taken mid-run
        rst = 1'b1;
        #1;
        chk(tx_req == 1'b0, "R8 req at reset assert", 64'(tx_req), 64'd0);
        @(negedge clk);
        chk(out_lanes == '0 && out_strobe == '0, "R8 outputs after reset edge",
            {24'd0, out_lanes, out_strobe}, 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_mode(2'd0, 2'd0, 1'b0, 40); // 1 lane, 32b, SDR
        run_mode(2'd0, 2'd0, 1'b1, 40); // 1 lane, 32b, DDR
        run_mode(2'd0, 2'd1, 1'b0, 40); // 1 lane, 16b, SDR
        run_mode(2'd0, 2'd1, 1'b1, 40);
        run_mode(2'd0, 2'd2, 1'b0, 40); // 1 lane, 8b
        run_mode(2'd0, 2'd2, 1'b1, 40);
        run_mode(2'd2, 2'd2, 1'b0, 40); // 4 lanes, 8b
        run_mode(2'd2, 2'd2, 1'b1, 40);
        run_mode(2'd1, 2'd1, 1'b1, 40); // 2 lanes, 16b, DDR
        run_mode(2'd1, 2'd1, 1'b0, 40);
        run_mode(2'd2, 2'd0, 1'b1, 20); // unsupported (R9)
        run_mode(2'd3, 2'd2, 1'b0, 20); // unsupported (R9)
        run_mode(2'd1, 2'd2, 1'b0, 40); // 2 lanes, 8b: upper lanes idle (R7)
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

endmodule